// File: doc/BRIEF.md
# Inter-core edge workload balancer

This block evens out pending graph-edge work across a group of processing cores. Each core keeps a small work table of neighbour-list index ranges. It also keeps a register that holds the total number of edges that are still pending in that table. A central controller wakes up once per balancing interval and compares the per-core totals. If the spread between the busiest and the idlest core is larger than a threshold, it moves part of one range from the busiest core to the idlest core.

The move runs as a register handshake. The controller marks one core as donor and one core as standby receiver. The donor's exchange agent carves the front half off its largest remaining range and reports that sub-range. The controller then copies the reported start and end indices into the receiver's two working registers and switches the receiver to receive. The receiver's agent files the sub-range as a new table entry and reports completion. The controller then adjusts both edge counts and returns both cores to idle. A donor with nothing worth splitting declines. A receiver with no free slot refuses, and the donor then takes its range back.

Work enters the tables through a load port. A read port shows any table slot, so that the effect of each attempt can be observed at the ports.

Top module: `edge_balancer`

## Requirements
- R1: A load on `loadValid` is accepted only when `busy` is low and `loadEnd > loadStart` and the addressed core has a free slot. An accepted load writes the lowest free slot and adds `loadEnd - loadStart` to that core's edge count. Any other load changes neither the table nor the count.
- R2: After reset all edge counts are 0, every control field is idle, every table slot is empty, `busy` is low and `endPulse` is low.
- R3: The controller looks at the counts once every INTERVAL cycles. It starts an attempt only when the largest count minus the smallest count is strictly greater than THRESHOLD, which defaults to 512.
- R4: The donor is the core with the largest count and the receiver is the core with the smallest count. When counts are equal, the lower core index wins both choices.
- R5: Each core has a 2-bit control field in `coreCtrl[2i+1:2i]`: 0 idle, 1 donating, 2 standby, 3 receiving. An attempt first shows the donor at 1 and the receiver at 2. If the donor offers a range, the receiver then moves to 3. At most one core is donating and at most one core is in standby or receiving at any time.
- R6: The donor picks its valid slot with the largest `end - start`, and the lower slot wins a tie. It gives away `floor(remaining/2)` edges as the range `[start, start+give)`, and that slot's start advances by `give`.
- R7: The receiver writes the offered start and end indices into its lowest free slot.
- R8: On success the donor count drops by the moved amount and the receiver count rises by the same amount. All control fields go back to idle. `endPulse` is high for one cycle with `endCode` = 1 and the donor, receiver and amount.
- R9: If the donor's largest remaining range holds fewer than 2 edges, the attempt ends with `endCode` = 2 and amount 0. No table and no count changes.
- R10: If the receiver has no free slot, the attempt ends with `endCode` = 3 and amount 0. The donor's slot start is restored and the counts are unchanged.
- R11: Each interval carries at most one attempt. No attempt changes the sum of all edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Request to add a range to a core's table |
| loadCore | input | CORE_W | Core that receives the loaded range |
| loadStart | input | IDX_W | First index of the loaded range |
| loadEnd | input | IDX_W | End index (exclusive) of the loaded range |
| rdCore | input | CORE_W | Core selected for table readout |
| rdSlot | input | SLOT_W | Slot selected for table readout |
| rdValid | output | 1 | Selected slot holds an entry |
| rdStart | output | IDX_W | Start index of the selected slot |
| rdEnd | output | IDX_W | End index of the selected slot |
| busy | output | 1 | A balancing attempt is in progress |
| coreCtrl | output | 2*NUM_CORES | Per-core balancing control fields |
| edgeCount | output | CNT_W*NUM_CORES | Per-core pending edge counts |
| endPulse | output | 1 | One-cycle pulse when an attempt ends |
| endCode | output | 2 | Outcome: 1 moved, 2 declined, 3 no slot |
| endDonor | output | CORE_W | Donor core of the ended attempt |
| endRecv | output | CORE_W | Receiver core of the ended attempt |
| endAmount | output | CNT_W | Edges moved (0 unless moved) |

## Verification
The refusal case is the hardest one to reach. The receiver has to be the core with the least pending work and also have every slot occupied. The bench reaches it by filling every core's table with one-edge ranges and giving the first core one large range, so the least-loaded core is also full. The decline case needs a spread above the threshold while every range stays below two edges. The bench therefore sets the threshold to 1 and loads two single-edge ranges onto one core. A load issued while an attempt is in flight is timed by polling `busy`.

// File: rtl/eb_pkg.sv
package eb_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'd0,
    CTL_DONATE  = 2'd1,
    CTL_STANDBY = 2'd2,
    CTL_RECEIVE = 2'd3
  } ctl_e;

  typedef enum logic [2:0] {
    AG_NONE,
    AG_OFFERED,
    AG_DECLINED,
    AG_ACCEPTED,
    AG_NOSLOT
  } agent_e;

  typedef struct packed {
    logic latchPair;
    logic copyWork;
    logic commitMove;
    logic endDecline;
    logic endNoSlot;
  } strobe_t;

  localparam logic [1:0] RES_MOVED    = 2'd1;
  localparam logic [1:0] RES_DECLINED = 2'd2;
  localparam logic [1:0] RES_NOSLOT   = 2'd3;

endpackage

// File: rtl/eb_agent.sv
module eb_agent
  import eb_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IDX_W = 16,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_e              ctrl,
  input  logic [IDX_W-1:0]  work0,
  input  logic [IDX_W-1:0]  work1,
  input  logic              loadReq,
  input  logic [IDX_W-1:0]  loadStart,
  input  logic [IDX_W-1:0]  loadEnd,
  input  logic              restoreStb,
  input  logic [SLOT_W-1:0] rdSlot,
  output agent_e            status,
  output logic [IDX_W-1:0]  offerStart,
  output logic [IDX_W-1:0]  offerEnd,
  output logic              loadTaken,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdStart,
  output logic [IDX_W-1:0]  rdEnd
);

  logic [SLOTS-1:0]  validQ;
  logic [IDX_W-1:0]  startQ [SLOTS];
  logic [IDX_W-1:0]  endQ   [SLOTS];
  logic [IDX_W-1:0]  remV   [SLOTS];
  logic [SLOT_W-1:0] savedSlotQ;
  logic [IDX_W-1:0]  savedStartQ;

  logic              bestFound;
  logic [SLOT_W-1:0] bestSlot;
  logic [IDX_W-1:0]  bestRem;
  logic              freeFound;
  logic [SLOT_W-1:0] freeSlot;
  logic [IDX_W-1:0]  giveAmt;

  // Remaining edges per slot, largest-range pick and lowest free slot
  always_comb begin
    bestFound = 1'b0;
    bestSlot  = '0;
    bestRem   = '0;
    freeFound = 1'b0;
    freeSlot  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      remV[i] = endQ[i] - startQ[i];
      if (validQ[i] && (!bestFound || remV[i] > bestRem)) begin
        bestFound = 1'b1;
        bestSlot  = SLOT_W'(i);
        bestRem   = remV[i];
      end
      if (!validQ[i] && !freeFound) begin
        freeFound = 1'b1;
        freeSlot  = SLOT_W'(i);
      end
    end
  end

  assign giveAmt   = bestRem >> 1;
  assign loadTaken = loadReq && freeFound && (ctrl == CTL_IDLE);

  assign rdValid = validQ[rdSlot];
  assign rdStart = startQ[rdSlot];
  assign rdEnd   = endQ[rdSlot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ      <= '0;
      status      <= AG_NONE;
      offerStart  <= '0;
      offerEnd    <= '0;
      savedSlotQ  <= '0;
      savedStartQ <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        startQ[i] <= '0;
        endQ[i]   <= '0;
      end
    end else begin
      if (ctrl == CTL_IDLE) begin
        status <= AG_NONE;
      end else if (status == AG_NONE) begin
        if (ctrl == CTL_DONATE) begin
          if (bestFound && bestRem >= IDX_W'(2)) begin
            offerStart         <= startQ[bestSlot];
            offerEnd           <= startQ[bestSlot] + giveAmt;
            startQ[bestSlot]   <= startQ[bestSlot] + giveAmt;
            savedSlotQ         <= bestSlot;
            savedStartQ        <= startQ[bestSlot];
            status             <= AG_OFFERED;
          end else begin
            status <= AG_DECLINED;
          end
        end else if (ctrl == CTL_RECEIVE) begin
          if (freeFound) begin
            validQ[freeSlot] <= 1'b1;
            startQ[freeSlot] <= work0;
            endQ[freeSlot]   <= work1;
            status           <= AG_ACCEPTED;
          end else begin
            status <= AG_NOSLOT;
          end
        end
      end
      if (restoreStb) begin
        startQ[savedSlotQ] <= savedStartQ;
      end
      if (loadTaken) begin
        validQ[freeSlot] <= 1'b1;
        startQ[freeSlot] <= loadStart;
        endQ[freeSlot]   <= loadEnd;
      end
    end
  end

endmodule

// File: rtl/eb_control.sv
module eb_control
  import eb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    overThreshold,
  input  agent_e  donorStat,
  input  agent_e  recvStat,
  output strobe_t stb,
  output logic    busy
);

  typedef enum logic [1:0] {C_IDLE, C_OFFER_WAIT, C_RECV_WAIT} cstate_e;

  cstate_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      C_IDLE: begin
        if (tick && overThreshold) begin
          stb.latchPair = 1'b1;
          stateD        = C_OFFER_WAIT;
        end
      end
      C_OFFER_WAIT: begin
        if (donorStat == AG_OFFERED) begin
          stb.copyWork = 1'b1;
          stateD       = C_RECV_WAIT;
        end else if (donorStat == AG_DECLINED) begin
          stb.endDecline = 1'b1;
          stateD         = C_IDLE;
        end
      end
      C_RECV_WAIT: begin
        if (recvStat == AG_ACCEPTED) begin
          stb.commitMove = 1'b1;
          stateD         = C_IDLE;
        end else if (recvStat == AG_NOSLOT) begin
          stb.endNoSlot = 1'b1;
          stateD        = C_IDLE;
        end
      end
      default: stateD = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= C_IDLE;
    else        stateQ <= stateD;
  end

  assign busy = (stateQ != C_IDLE);

endmodule

// File: rtl/eb_datapath.sv
module eb_datapath
  import eb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 4,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 16,
  parameter int INTERVAL  = 64,
  parameter int THRESHOLD = 512,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  strobe_t                    stb,
  input  logic                       busy,
  input  logic                       loadValid,
  input  logic [CORE_W-1:0]          loadCore,
  input  logic [IDX_W-1:0]           loadStart,
  input  logic [IDX_W-1:0]           loadEnd,
  input  logic [CORE_W-1:0]          rdCore,
  input  logic [SLOT_W-1:0]          rdSlot,
  output logic                       tick,
  output logic                       overThreshold,
  output agent_e                     donorStat,
  output agent_e                     recvStat,
  output logic                       rdValid,
  output logic [IDX_W-1:0]           rdStart,
  output logic [IDX_W-1:0]           rdEnd,
  output logic [2*NUM_CORES-1:0]     coreCtrl,
  output logic [CNT_W*NUM_CORES-1:0] edgeCount,
  output logic                       endPulse,
  output logic [1:0]                 endCode,
  output logic [CORE_W-1:0]          endDonor,
  output logic [CORE_W-1:0]          endRecv,
  output logic [CNT_W-1:0]           endAmount
);

  localparam int TICK_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESHOLD);

  logic [TICK_W-1:0] tickCntQ;
  logic [CNT_W-1:0]  cntQ   [NUM_CORES];
  ctl_e              ctrlQ  [NUM_CORES];
  logic [IDX_W-1:0]  work0Q [NUM_CORES];
  logic [IDX_W-1:0]  work1Q [NUM_CORES];
  logic [CORE_W-1:0] donorQ, recvQ;
  logic [CNT_W-1:0]  giveQ;

  agent_e            agStat   [NUM_CORES];
  logic [IDX_W-1:0]  agOfferS [NUM_CORES];
  logic [IDX_W-1:0]  agOfferE [NUM_CORES];
  logic [IDX_W-1:0]  agRdS    [NUM_CORES];
  logic [IDX_W-1:0]  agRdE    [NUM_CORES];
  logic [NUM_CORES-1:0] agRdValid, agLoadTaken, loadReqV, restoreV;

  logic [CORE_W-1:0] maxIdx, minIdx;
  logic [CNT_W-1:0]  maxVal, minVal;
  logic              loadOk;
  logic [CNT_W-1:0]  loadLen;

  // Balancing interval timer
  assign tick = (tickCntQ == TICK_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tickCntQ <= '0;
    else if (tick) tickCntQ <= '0;
    else           tickCntQ <= tickCntQ + 1'b1;
  end

  // Busiest and idlest core, lower index on ties
  always_comb begin
    maxIdx = '0;
    minIdx = '0;
    maxVal = cntQ[0];
    minVal = cntQ[0];
    for (int i = 1; i < NUM_CORES; i++) begin
      if (cntQ[i] > maxVal) begin
        maxVal = cntQ[i];
        maxIdx = CORE_W'(i);
      end
      if (cntQ[i] < minVal) begin
        minVal = cntQ[i];
        minIdx = CORE_W'(i);
      end
    end
  end

  assign overThreshold = (maxVal - minVal) > THR;
  assign donorStat     = agStat[donorQ];
  assign recvStat      = agStat[recvQ];

  assign loadOk  = loadValid && !busy && (loadEnd > loadStart);
  assign loadLen = CNT_W'(loadEnd - loadStart);

  // Per-core exchange agents
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign loadReqV[g] = loadOk && (loadCore == CORE_W'(g));
    assign restoreV[g] = stb.endNoSlot && (donorQ == CORE_W'(g));

    eb_agent #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_agent (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrlQ[g]),
      .work0     (work0Q[g]),
      .work1     (work1Q[g]),
      .loadReq   (loadReqV[g]),
      .loadStart (loadStart),
      .loadEnd   (loadEnd),
      .restoreStb(restoreV[g]),
      .rdSlot    (rdSlot),
      .status    (agStat[g]),
      .offerStart(agOfferS[g]),
      .offerEnd  (agOfferE[g]),
      .loadTaken (agLoadTaken[g]),
      .rdValid   (agRdValid[g]),
      .rdStart   (agRdS[g]),
      .rdEnd     (agRdE[g])
    );

    assign edgeCount[g*CNT_W +: CNT_W] = cntQ[g];
    assign coreCtrl[g*2 +: 2]          = ctrlQ[g];
  end

  assign rdValid = agRdValid[rdCore];
  assign rdStart = agRdS[rdCore];
  assign rdEnd   = agRdE[rdCore];

  // Registers shared by the controller and the cores
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      donorQ    <= '0;
      recvQ     <= '0;
      giveQ     <= '0;
      endPulse  <= 1'b0;
      endCode   <= '0;
      endDonor  <= '0;
      endRecv   <= '0;
      endAmount <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        cntQ[i]   <= '0;
        ctrlQ[i]  <= CTL_IDLE;
        work0Q[i] <= '0;
        work1Q[i] <= '0;
      end
    end else begin
      endPulse <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++) begin
        if (agLoadTaken[i]) cntQ[i] <= cntQ[i] + loadLen;
      end
      if (stb.latchPair) begin
        donorQ        <= maxIdx;
        recvQ         <= minIdx;
        ctrlQ[maxIdx] <= CTL_DONATE;
        ctrlQ[minIdx] <= CTL_STANDBY;
      end
      if (stb.copyWork) begin
        work0Q[recvQ] <= agOfferS[donorQ];
        work1Q[recvQ] <= agOfferE[donorQ];
        giveQ         <= CNT_W'(agOfferE[donorQ] - agOfferS[donorQ]);
        ctrlQ[recvQ]  <= CTL_RECEIVE;
      end
      if (stb.commitMove || stb.endDecline || stb.endNoSlot) begin
        for (int i = 0; i < NUM_CORES; i++) ctrlQ[i] <= CTL_IDLE;
        endPulse <= 1'b1;
        endDonor <= donorQ;
        endRecv  <= recvQ;
      end
      if (stb.commitMove) begin
        cntQ[donorQ] <= cntQ[donorQ] - giveQ;
        cntQ[recvQ]  <= cntQ[recvQ] + giveQ;
        endCode      <= RES_MOVED;
        endAmount    <= giveQ;
      end
      if (stb.endDecline) begin
        endCode   <= RES_DECLINED;
        endAmount <= '0;
      end
      if (stb.endNoSlot) begin
        endCode   <= RES_NOSLOT;
        endAmount <= '0;
      end
    end
  end

endmodule

// File: rtl/edge_balancer.sv
module edge_balancer
  import eb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 4,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 16,
  parameter int INTERVAL  = 64,
  parameter int THRESHOLD = 512,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       loadValid,
  input  logic [CORE_W-1:0]          loadCore,
  input  logic [IDX_W-1:0]           loadStart,
  input  logic [IDX_W-1:0]           loadEnd,
  input  logic [CORE_W-1:0]          rdCore,
  input  logic [SLOT_W-1:0]          rdSlot,
  output logic                       rdValid,
  output logic [IDX_W-1:0]           rdStart,
  output logic [IDX_W-1:0]           rdEnd,
  output logic                       busy,
  output logic [2*NUM_CORES-1:0]     coreCtrl,
  output logic [CNT_W*NUM_CORES-1:0] edgeCount,
  output logic                       endPulse,
  output logic [1:0]                 endCode,
  output logic [CORE_W-1:0]          endDonor,
  output logic [CORE_W-1:0]          endRecv,
  output logic [CNT_W-1:0]           endAmount
);

  strobe_t stb;
  logic    tick, overThreshold;
  agent_e  donorStat, recvStat;

  eb_control u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .overThreshold(overThreshold),
    .donorStat    (donorStat),
    .recvStat     (recvStat),
    .stb          (stb),
    .busy         (busy)
  );

  eb_datapath #(
    .NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .INTERVAL(INTERVAL), .THRESHOLD(THRESHOLD)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .busy         (busy),
    .loadValid    (loadValid),
    .loadCore     (loadCore),
    .loadStart    (loadStart),
    .loadEnd      (loadEnd),
    .rdCore       (rdCore),
    .rdSlot       (rdSlot),
    .tick         (tick),
    .overThreshold(overThreshold),
    .donorStat    (donorStat),
    .recvStat     (recvStat),
    .rdValid      (rdValid),
    .rdStart      (rdStart),
    .rdEnd        (rdEnd),
    .coreCtrl     (coreCtrl),
    .edgeCount    (edgeCount),
    .endPulse     (endPulse),
    .endCode      (endCode),
    .endDonor     (endDonor),
    .endRecv      (endRecv),
    .endAmount    (endAmount)
  );

endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic [2*NUM_CORES-1:0]     coreCtrl,
  input logic [CNT_W*NUM_CORES-1:0] edgeCount,
  input logic                       endPulse,
  input logic [1:0]                 endCode,
  input logic [CNT_W-1:0]           endAmount
);

  localparam int SUM_W = CNT_W + $clog2(NUM_CORES + 1);

  logic [NUM_CORES-1:0] donorVec, takerVec;
  logic [SUM_W-1:0]     total;

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      donorVec[i] = (coreCtrl[2*i +: 2] == 2'd1);
      takerVec[i] = (coreCtrl[2*i +: 2] == 2'd2) || (coreCtrl[2*i +: 2] == 2'd3);
      total       = total + SUM_W'(edgeCount[i*CNT_W +: CNT_W]);
    end
  end

  // R5: a single donor and a single taker, always raised and cleared as a pair
  p_one_donor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(donorVec) <= 1);
  p_one_taker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(takerVec) <= 1);
  p_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|donorVec) == (|takerVec));

  // R8: the end pulse lasts one cycle and marks every return to idle
  p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    endPulse |=> !endPulse);
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> endPulse);
  p_moved_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (endPulse && endCode == 2'd1) |-> (endAmount != '0));

  // R11: an attempt in flight never changes the total pending work
  p_conserve_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (total == $past(total)));

endmodule

bind edge_balancer eb_checker #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .coreCtrl (coreCtrl),
  .edgeCount(edgeCount),
  .endPulse (endPulse),
  .endCode  (endCode),
  .endAmount(endAmount)
);

// File: tb/edge_balancer_test.sv
`timescale 1ns/1ps
module edge_balancer_test;

  localparam int NC   = 4;
  localparam int NS   = 2;
  localparam int IW   = 16;
  localparam int CW   = 16;
  localparam int IVL  = 32;
  localparam int THR  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadValid = 1'b0;
  logic [1:0] loadCore = '0;
  logic [IW-1:0] loadStart = '0, loadEnd = '0;
  logic [1:0] rdCore = '0;
  logic rdSlot = 1'b0;
  logic rdValid;
  logic [IW-1:0] rdStart, rdEnd;
  logic busy;
  logic [2*NC-1:0] coreCtrl;
  logic [CW*NC-1:0] edgeCount;
  logic endPulse;
  logic [1:0] endCode;
  logic [1:0] endDonor, endRecv;
  logic [CW-1:0] endAmount;

  int checks = 0;
  int errors = 0;
  bit sawStandby, sawReceive;

  always #10 clk = ~clk;

  edge_balancer #(.NUM_CORES(NC), .SLOTS(NS), .IDX_W(IW), .CNT_W(CW),
                  .INTERVAL(IVL), .THRESHOLD(THR)) uut (
    .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .loadCore(loadCore),
    .loadStart(loadStart), .loadEnd(loadEnd), .rdCore(rdCore), .rdSlot(rdSlot),
    .rdValid(rdValid), .rdStart(rdStart), .rdEnd(rdEnd), .busy(busy),
    .coreCtrl(coreCtrl), .edgeCount(edgeCount), .endPulse(endPulse),
    .endCode(endCode), .endDonor(endDonor), .endRecv(endRecv), .endAmount(endAmount)
  );

  function automatic int cntOf(int c);
    return int'(edgeCount[c*CW +: CW]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic doReset();
    loadValid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic loadEntry(input int c, input int s, input int e);
    loadCore  = 2'(c);
    loadStart = IW'(s);
    loadEnd   = IW'(e);
    loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic readSlot(input int c, input int sl, output int v, output int s, output int e);
    rdCore = 2'(c);
    rdSlot = sl[0];
    #1;
    v = int'(rdValid);
    s = int'(rdStart);
    e = int'(rdEnd);
  endtask

  task automatic waitEnd(input int maxCycles, output bit got);
    got = 1'b0;
    sawStandby = 1'b0;
    sawReceive = 1'b0;
    for (int n = 0; n < maxCycles && !got; n++) begin
      @(negedge clk);
      for (int a = 0; a < NC; a++)
        for (int b = 0; b < NC; b++)
          if (coreCtrl[2*a +: 2] == 2'd1) begin
            if (coreCtrl[2*b +: 2] == 2'd2) sawStandby = 1'b1;
            if (coreCtrl[2*b +: 2] == 2'd3) sawReceive = 1'b1;
          end
      if (endPulse) got = 1'b1;
    end
  endtask

  task automatic testReset();
    int v, s, e;
    doReset();
    for (int c = 0; c < NC; c++) checkEq("R2 count after reset", cntOf(c), 0);
    checkEq("R2 ctrl idle", int'(coreCtrl), 0);
    checkEq("R2 busy low", int'(busy), 0);
    checkEq("R2 endPulse low", int'(endPulse), 0);
    readSlot(0, 0, v, s, e);
    checkEq("R2 slot empty", v, 0);
  endtask

  task automatic testLoad();
    int v, s, e;
    doReset();
    loadEntry(2, 10, 30);
    checkEq("R1 count after load", cntOf(2), 20);
    readSlot(2, 0, v, s, e);
    checkEq("R1 slot valid", v, 1);
    checkEq("R1 slot start", s, 10);
    checkEq("R1 slot end", e, 30);
    loadEntry(2, 7, 7);
    checkEq("R1 empty range ignored count", cntOf(2), 20);
    readSlot(2, 1, v, s, e);
    checkEq("R1 empty range ignored slot", v, 0);
  endtask

  task automatic testThresholdDecline();
    bit got, everBusy;
    int v, s, e;
    doReset();
    loadEntry(0, 0, 1);
    everBusy = 1'b0;
    got = 1'b0;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (busy) everBusy = 1'b1;
      if (endPulse) got = 1'b1;
    end
    checkEq("R3 spread equal to threshold starts nothing", int'(everBusy | got), 0);
    loadEntry(0, 5, 6);
    waitEnd(3 * IVL, got);
    checkEq("R3 spread above threshold starts attempt", int'(got), 1);
    checkEq("R9 decline code", int'(endCode), 2);
    checkEq("R9 decline amount", int'(endAmount), 0);
    checkEq("R9 donor count kept", cntOf(0), 2);
    checkEq("R9 receiver count kept", cntOf(1), 0);
    readSlot(0, 0, v, s, e);
    checkEq("R9 donor slot0 start kept", s, 0);
    readSlot(1, 0, v, s, e);
    checkEq("R9 receiver table untouched", v, 0);
    checkEq("R9 ctrl back to idle", int'(coreCtrl), 0);
  endtask

  task automatic testPairing();
    bit got;
    int v, s, e;
    doReset();
    loadEntry(2, 0, 10);
    loadEntry(3, 0, 10);
    waitEnd(3 * IVL, got);
    checkEq("R8 first attempt ended", int'(got), 1);
    checkEq("R4 donor tie lower index", int'(endDonor), 2);
    checkEq("R4 receiver tie lower index", int'(endRecv), 0);
    checkEq("R8 moved code", int'(endCode), 1);
    checkEq("R8 moved amount", int'(endAmount), 5);
    checkEq("R5 donate with standby seen", int'(sawStandby), 1);
    checkEq("R5 donate with receive seen", int'(sawReceive), 1);
    checkEq("R8 donor count", cntOf(2), 5);
    checkEq("R8 receiver count", cntOf(0), 5);
    checkEq("R8 ctrl idle at end", int'(coreCtrl), 0);
    readSlot(0, 0, v, s, e);
    checkEq("R7 receiver entry valid", v, 1);
    checkEq("R7 receiver entry start", s, 0);
    checkEq("R7 receiver entry end", e, 5);
    readSlot(2, 0, v, s, e);
    checkEq("R6 donor start advanced", s, 5);
    checkEq("R6 donor end kept", e, 10);
    waitEnd(3 * IVL, got);
    checkEq("R11 next interval attempt", int'(got), 1);
    checkEq("R4 second donor", int'(endDonor), 3);
    checkEq("R4 second receiver", int'(endRecv), 1);
    for (int c = 0; c < NC; c++) checkEq("R8 balanced count", cntOf(c), 5);
  endtask

  task automatic testLargestEntry();
    bit got;
    int v, s, e;
    doReset();
    loadEntry(0, 100, 104);
    loadEntry(0, 200, 211);
    while (!busy) @(negedge clk);
    loadEntry(3, 0, 50);
    waitEnd(3 * IVL, got);
    checkEq("R6 attempt ended", int'(got), 1);
    checkEq("R6 moved amount is half rounded down", int'(endAmount), 5);
    readSlot(0, 1, v, s, e);
    checkEq("R6 largest slot start advanced", s, 205);
    readSlot(0, 0, v, s, e);
    checkEq("R6 smaller slot untouched", s, 100);
    readSlot(1, 0, v, s, e);
    checkEq("R7 receiver start", s, 200);
    checkEq("R7 receiver end", e, 205);
    checkEq("R8 donor count", cntOf(0), 10);
    checkEq("R8 receiver count", cntOf(1), 5);
    checkEq("R1 load while busy ignored count", cntOf(3), 0);
    readSlot(3, 0, v, s, e);
    checkEq("R1 load while busy ignored slot", v, 0);
  endtask

  task automatic testNoSlot();
    bit got;
    int v, s, e;
    doReset();
    loadEntry(0, 0, 100);
    loadEntry(0, 0, 1);
    for (int c = 1; c < NC; c++) begin
      loadEntry(c, 0, 1);
      loadEntry(c, 2, 3);
    end
    waitEnd(3 * IVL, got);
    checkEq("R10 attempt ended", int'(got), 1);
    checkEq("R10 no slot code", int'(endCode), 3);
    checkEq("R10 amount zero", int'(endAmount), 0);
    checkEq("R10 receiver choice", int'(endRecv), 1);
    readSlot(0, 0, v, s, e);
    checkEq("R10 donor start restored", s, 0);
    checkEq("R10 donor end kept", e, 100);
    checkEq("R10 donor count kept", cntOf(0), 101);
    checkEq("R10 receiver count kept", cntOf(1), 2);
    readSlot(1, 1, v, s, e);
    checkEq("R10 receiver slot kept", s, 2);
    checkEq("R10 ctrl idle", int'(coreCtrl), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testLoad();
    testThresholdDecline();
    testPairing();
    testLargestEntry();
    testNoSlot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule